// File: doc/BRIEF.md
# Circular Line-Buffer Image Cache

This block holds a small number of rows of an input feature map in on-chip memory for a 3x3 convolution engine. Pixel words arrive as a stream, ordered by row, then column, then channel. Each accepted word goes to a write pointer that advances by one and wraps to zero at the end of the ring. The ring spans `NUM_LINES` cache lines, and each line holds `chans*width` words. Because of the wrap, row `y + NUM_LINES` overwrites row `y`. The feeding controller first loads row 0 plus one pixel. After that it supplies one pixel per output position, so the cache always holds the rows that the current window needs.

A per-layer configuration strobe loads width, height and channel count. It recomputes the line length, resets the write pointer, and arms a counter of the words still expected for the layer. The controller can then request one of two reads:

- a 3x3 neighbourhood of a centre pixel for one input channel, delivered as nine taps;
- one addressed pixel.

Any position outside the image reads as zero, which gives a padding of one for the convolution. A request takes nine memory reads in sequence (a single-pixel read takes one). A busy flag guards the block until the result pulse.

Top module: `ring_img_cache`

## Requirements
- R1: After reset, `busy_o` and `rd_valid_o` are low.
- R2: A word for pixel (y,x) and channel c of a held row is stored at ring position (y mod NUM_LINES)*chans*width + x*chans + c. A single-pixel read of (y,x,c) returns that word on `px_data_o`.
- R3: The write position wraps to 0 after chans*width*NUM_LINES words, so row y+NUM_LINES replaces row y while the other held rows stay intact.
- R4: Any read at x<0, x>=width, y<0 or y>=height returns 0.
- R5: Tap k=j*3+i of a window read holds the pixel at (y+j-1, x+i-1) for the requested channel. Tap k occupies bits [k*DATA_W +: DATA_W] of `win_data_o`.
- R6: After a configuration, only the first chans*width*height stream words are stored. Later words are discarded and leave memory unchanged.
- R7: A configuration strobe resets the write position to 0 and re-arms the load count for the new geometry.
- R8: `rd_valid_o` is a one-cycle pulse. It appears 10 cycles after the clock edge that accepts a window request, or 2 cycles after a single-pixel request.
- R9: `busy_o` is high from the cycle after acceptance until the result pulse, and low during the pulse. A request made while busy is ignored and produces no extra pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_valid_i | input | 1 | Load the layer geometry |
| cfg_width_i | input | $clog2(MAX_W+1) | Image width in pixels |
| cfg_height_i | input | $clog2(MAX_H+1) | Image height in rows |
| cfg_chans_i | input | $clog2(MAX_CH+1) | Input channels per pixel |
| wr_valid_i | input | 1 | Stream word present |
| wr_data_i | input | DATA_W | Stream word, signed fixed point |
| req_valid_i | input | 1 | Read request |
| req_single_i | input | 1 | 1: single pixel, 0: 3x3 window |
| req_y_i | input | COORD_W | Centre row, signed |
| req_x_i | input | COORD_W | Centre column, signed |
| req_ch_i | input | $clog2(MAX_CH) | Input channel |
| busy_o | output | 1 | Request in progress |
| rd_valid_o | output | 1 | Result ready pulse |
| win_data_o | output | 9*DATA_W | Window taps, tap k at bits k*DATA_W |
| px_data_o | output | DATA_W | Single-pixel result |

## Verification
Several properties are checked on every cycle by assertions:
- the write pointer never leaves the ring;
- a configuration strobe clears the pointer;
- an exhausted load count stays at zero;
- the result pulse lasts one cycle and never coincides with busy;
- latched request coordinates hold steady while reads are issued.

Other behaviour can only be shown by the bench's scenarios:
- the data placement and tap order;
- zero padding at every image edge;
- correct reads after the ring wraps;
- the dropping of excess stream words;
- the exact latency;
- the ignoring of a request made while busy.

// File: rtl/ring_cache_pkg.sv
package ring_cache_pkg;
  localparam int TAPS = 9;
  typedef enum logic [1:0] {RD_IDLE, RD_ISSUE, RD_WAIT} rd_state_e;
endpackage

// File: rtl/ring_ram.sv
module ring_ram #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 2048,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/ring_wr_ctrl.sv
module ring_wr_ctrl #(
  parameter int DATA_W    = 16,
  parameter int NUM_LINES = 4,
  parameter int MAX_W     = 32,
  parameter int MAX_H     = 32,
  parameter int MAX_CH    = 16,
  localparam int W_W      = $clog2(MAX_W + 1),
  localparam int H_W      = $clog2(MAX_H + 1),
  localparam int C_W      = $clog2(MAX_CH + 1),
  localparam int LINE_MAX = MAX_W * MAX_CH,
  localparam int LW_W     = $clog2(LINE_MAX + 1),
  localparam int RC_W     = $clog2(LINE_MAX * MAX_H + 1),
  localparam int ADDR_W   = $clog2(NUM_LINES * LINE_MAX)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_valid_i,
  input  logic [W_W-1:0]    cfg_width_i,
  input  logic [H_W-1:0]    cfg_height_i,
  input  logic [C_W-1:0]    cfg_chans_i,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_waddr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic [W_W-1:0]    width_o,
  output logic [H_W-1:0]    height_o,
  output logic [C_W-1:0]    chans_o,
  output logic [LW_W-1:0]   line_w_o
);
  logic [LW_W-1:0]   lw_q;
  logic [RC_W-1:0]   remain_q;
  logic [ADDR_W-1:0] wr_addr_q;
  logic [W_W-1:0]    width_q;
  logic [H_W-1:0]    height_q;
  logic [C_W-1:0]    chans_q;
  int ring_words;

  assign ring_words  = int'(lw_q) * NUM_LINES;
  assign mem_we_o    = wr_valid_i && (remain_q != '0);
  assign mem_waddr_o = wr_addr_q;
  assign mem_wdata_o = wr_data_i;
  assign width_o     = width_q;
  assign height_o    = height_q;
  assign chans_o     = chans_q;
  assign line_w_o    = lw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lw_q      <= '0;
      remain_q  <= '0;
      wr_addr_q <= '0;
      width_q   <= '0;
      height_q  <= '0;
      chans_q   <= '0;
    end else if (cfg_valid_i) begin
      width_q   <= cfg_width_i;
      height_q  <= cfg_height_i;
      chans_q   <= cfg_chans_i;
      lw_q      <= LW_W'(int'(cfg_chans_i) * int'(cfg_width_i));
      remain_q  <= RC_W'(int'(cfg_chans_i) * int'(cfg_width_i) * int'(cfg_height_i));
      wr_addr_q <= '0;
    end else if (mem_we_o) begin
      remain_q  <= remain_q - 1'b1;
      wr_addr_q <= (int'(wr_addr_q) == ring_words - 1) ? '0 : wr_addr_q + 1'b1;
    end
  end

  // R3
  addr_in_ring_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ring_words != 0) |-> (int'(wr_addr_q) < ring_words));
  // R7
  cfg_clears_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_i |=> (wr_addr_q == '0));
  // R6
  remain_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (remain_q == '0 && !cfg_valid_i) |=> (remain_q == '0));
endmodule

// File: rtl/ring_win_reader.sv
module ring_win_reader
  import ring_cache_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int NUM_LINES = 4,
  parameter int MAX_W     = 32,
  parameter int MAX_H     = 32,
  parameter int MAX_CH    = 16,
  localparam int W_W      = $clog2(MAX_W + 1),
  localparam int H_W      = $clog2(MAX_H + 1),
  localparam int C_W      = $clog2(MAX_CH + 1),
  localparam int CI_W     = $clog2(MAX_CH),
  localparam int COORD_W  = ((W_W > H_W) ? W_W : H_W) + 1,
  localparam int LINE_MAX = MAX_W * MAX_CH,
  localparam int LW_W     = $clog2(LINE_MAX + 1),
  localparam int ADDR_W   = $clog2(NUM_LINES * LINE_MAX)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [W_W-1:0]            width_i,
  input  logic [H_W-1:0]            height_i,
  input  logic [C_W-1:0]            chans_i,
  input  logic [LW_W-1:0]           line_w_i,
  input  logic                      req_valid_i,
  input  logic                      req_single_i,
  input  logic signed [COORD_W-1:0] req_y_i,
  input  logic signed [COORD_W-1:0] req_x_i,
  input  logic [CI_W-1:0]           req_ch_i,
  output logic                      mem_re_o,
  output logic [ADDR_W-1:0]         mem_raddr_o,
  input  logic [DATA_W-1:0]         mem_rdata_i,
  output logic                      busy_o,
  output logic                      rd_valid_o,
  output logic [TAPS*DATA_W-1:0]    win_data_o,
  output logic [DATA_W-1:0]         px_data_o
);
  rd_state_e state_q;
  logic signed [COORD_W-1:0] y_q, x_q;
  logic [CI_W-1:0] ch_q;
  logic            single_q;
  logic [3:0]      idx_q;
  logic            rd_vld_q, rd_pad_q, rd_last_q, valid_q;
  logic [3:0]      rd_slot_q;
  logic [DATA_W-1:0] taps_q [TAPS];
  logic [DATA_W-1:0] px_q;
  logic pad, last;
  int jj, ii, ny, nx, addr;

  always_comb begin
    jj   = single_q ? 1 : int'(idx_q) / 3;
    ii   = single_q ? 1 : int'(idx_q) % 3;
    ny   = int'(y_q) + jj - 1;
    nx   = int'(x_q) + ii - 1;
    pad  = (ny < 0) || (ny >= int'(height_i)) || (nx < 0) || (nx >= int'(width_i));
    addr = pad ? 0 : (ny % NUM_LINES) * int'(line_w_i) + nx * int'(chans_i) + int'(ch_q);
    last = single_q || (idx_q == 4'd8);
  end

  assign mem_re_o    = (state_q == RD_ISSUE);
  assign mem_raddr_o = ADDR_W'(addr);
  assign busy_o      = (state_q != RD_IDLE);
  assign rd_valid_o  = valid_q;
  assign px_data_o   = px_q;

  for (genvar k = 0; k < TAPS; k++) begin : g_taps
    assign win_data_o[k*DATA_W +: DATA_W] = taps_q[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= RD_IDLE;
      y_q       <= '0;
      x_q       <= '0;
      ch_q      <= '0;
      single_q  <= 1'b0;
      idx_q     <= '0;
      rd_vld_q  <= 1'b0;
      rd_pad_q  <= 1'b0;
      rd_last_q <= 1'b0;
      rd_slot_q <= '0;
    end else begin
      rd_vld_q <= 1'b0;
      unique case (state_q)
        RD_IDLE: if (req_valid_i) begin
          y_q      <= req_y_i;
          x_q      <= req_x_i;
          ch_q     <= req_ch_i;
          single_q <= req_single_i;
          idx_q    <= '0;
          state_q  <= RD_ISSUE;
        end
        RD_ISSUE: begin
          rd_vld_q  <= 1'b1;
          rd_slot_q <= idx_q;
          rd_pad_q  <= pad;
          rd_last_q <= last;
          if (last) state_q <= RD_WAIT;
          else      idx_q   <= idx_q + 1'b1;
        end
        RD_WAIT: if (rd_vld_q && rd_last_q) state_q <= RD_IDLE;
        default: state_q <= RD_IDLE;
      endcase
    end
  end

  // capture stage: memory data is valid one cycle after issue
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      px_q    <= '0;
      for (int k = 0; k < TAPS; k++) taps_q[k] <= '0;
    end else begin
      valid_q <= rd_vld_q && rd_last_q;
      if (rd_vld_q) begin
        if (single_q) px_q <= rd_pad_q ? '0 : mem_rdata_i;
        else          taps_q[rd_slot_q] <= rd_pad_q ? '0 : mem_rdata_i;
      end
    end
  end

  // R8
  pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o);
  // R9
  valid_not_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> !busy_o);
  // R9
  coords_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RD_ISSUE) |=> ($stable(y_q) && $stable(x_q) && $stable(ch_q)));
endmodule

// File: rtl/ring_img_cache.sv
module ring_img_cache
  import ring_cache_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int NUM_LINES = 4,
  parameter int MAX_W     = 32,
  parameter int MAX_H     = 32,
  parameter int MAX_CH    = 16,
  localparam int W_W      = $clog2(MAX_W + 1),
  localparam int H_W      = $clog2(MAX_H + 1),
  localparam int C_W      = $clog2(MAX_CH + 1),
  localparam int CI_W     = $clog2(MAX_CH),
  localparam int COORD_W  = ((W_W > H_W) ? W_W : H_W) + 1,
  localparam int LINE_MAX = MAX_W * MAX_CH,
  localparam int LW_W     = $clog2(LINE_MAX + 1),
  localparam int DEPTH    = NUM_LINES * LINE_MAX,
  localparam int ADDR_W   = $clog2(DEPTH)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cfg_valid_i,
  input  logic [W_W-1:0]            cfg_width_i,
  input  logic [H_W-1:0]            cfg_height_i,
  input  logic [C_W-1:0]            cfg_chans_i,
  input  logic                      wr_valid_i,
  input  logic [DATA_W-1:0]         wr_data_i,
  input  logic                      req_valid_i,
  input  logic                      req_single_i,
  input  logic signed [COORD_W-1:0] req_y_i,
  input  logic signed [COORD_W-1:0] req_x_i,
  input  logic [CI_W-1:0]           req_ch_i,
  output logic                      busy_o,
  output logic                      rd_valid_o,
  output logic [TAPS*DATA_W-1:0]    win_data_o,
  output logic [DATA_W-1:0]         px_data_o
);
  logic              we, re;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [DATA_W-1:0] wdata, rdata;
  logic [W_W-1:0]    width;
  logic [H_W-1:0]    height;
  logic [C_W-1:0]    chans;
  logic [LW_W-1:0]   line_w;

  ring_wr_ctrl #(
    .DATA_W(DATA_W), .NUM_LINES(NUM_LINES), .MAX_W(MAX_W), .MAX_H(MAX_H), .MAX_CH(MAX_CH)
  ) u_wr (
    .clk_i, .rst_ni, .cfg_valid_i, .cfg_width_i, .cfg_height_i, .cfg_chans_i,
    .wr_valid_i, .wr_data_i,
    .mem_we_o(we), .mem_waddr_o(waddr), .mem_wdata_o(wdata),
    .width_o(width), .height_o(height), .chans_o(chans), .line_w_o(line_w)
  );

  ring_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
    .clk_i, .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
    .re_i(re), .raddr_i(raddr), .rdata_o(rdata)
  );

  ring_win_reader #(
    .DATA_W(DATA_W), .NUM_LINES(NUM_LINES), .MAX_W(MAX_W), .MAX_H(MAX_H), .MAX_CH(MAX_CH)
  ) u_rd (
    .clk_i, .rst_ni, .width_i(width), .height_i(height), .chans_i(chans), .line_w_i(line_w),
    .req_valid_i, .req_single_i, .req_y_i, .req_x_i, .req_ch_i,
    .mem_re_o(re), .mem_raddr_o(raddr), .mem_rdata_i(rdata),
    .busy_o, .rd_valid_o, .win_data_o, .px_data_o
  );
endmodule

// File: tb/tb_ring_img_cache.sv
`timescale 1ns/1ps
module tb_ring_img_cache;
  localparam int DW = 16, NL = 4, MW = 8, MH = 8, MC = 4;
  localparam int W_W = $clog2(MW + 1), H_W = $clog2(MH + 1), C_W = $clog2(MC + 1);
  localparam int CI_W = $clog2(MC);
  localparam int CW = ((W_W > H_W) ? W_W : H_W) + 1;

  logic clk = 0, rst_n = 0;
  logic cfg_valid = 0, wr_valid = 0, req_valid = 0, req_single = 0;
  logic [W_W-1:0] cfg_w = '0;
  logic [H_W-1:0] cfg_h = '0;
  logic [C_W-1:0] cfg_c = '0;
  logic [DW-1:0] wr_data = '0;
  logic signed [CW-1:0] req_y = '0, req_x = '0;
  logic [CI_W-1:0] req_ch = '0;
  logic busy, rd_valid;
  logic [9*DW-1:0] win;
  logic [DW-1:0] px;
  int tests = 0, fails = 0, cycles = 0;

  always #2.5 clk = ~clk;

  ring_img_cache #(.DATA_W(DW), .NUM_LINES(NL), .MAX_W(MW), .MAX_H(MH), .MAX_CH(MC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_valid_i(cfg_valid), .cfg_width_i(cfg_w),
    .cfg_height_i(cfg_h), .cfg_chans_i(cfg_c), .wr_valid_i(wr_valid), .wr_data_i(wr_data),
    .req_valid_i(req_valid), .req_single_i(req_single), .req_y_i(req_y), .req_x_i(req_x),
    .req_ch_i(req_ch), .busy_o(busy), .rd_valid_o(rd_valid), .win_data_o(win), .px_data_o(px)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      fails++;
      $display("FAIL watchdog R8: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int pixv(int base, int y, int x, int c, int w, int h);
    if (y < 0 || y >= h || x < 0 || x >= w) return 0;
    return base + y * 100 + x * 10 + c + 1;
  endfunction

  task automatic configure(int w, int h, int c);
    @(negedge clk);
    cfg_valid = 1; cfg_w = W_W'(w); cfg_h = H_W'(h); cfg_c = C_W'(c);
    @(negedge clk);
    cfg_valid = 0;
  endtask

  task automatic push_rows(int base, int y0, int y1, int w, int c);
    for (int y = y0; y <= y1; y++)
      for (int x = 0; x < w; x++)
        for (int k = 0; k < c; k++) begin
          @(negedge clk);
          wr_valid = 1; wr_data = DW'(pixv(base, y, x, k, w, 99));
        end
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic request(bit single, int y, int x, int c, output int lat);
    @(negedge clk);
    req_valid = 1; req_single = single; req_y = CW'(y); req_x = CW'(x); req_ch = CI_W'(c);
    @(negedge clk);
    req_valid = 0;
    check(busy == 1'b1, "R9", "busy after accept", int'(busy), 1);
    lat = 0;
    while (!rd_valid && lat < 40) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic check_window(int base, int y, int x, int c, int w, int h);
    int lat;
    request(0, y, x, c, lat);
    check(lat == 10, "R8", "window latency", lat, 10);
    for (int j = 0; j < 3; j++)
      for (int i = 0; i < 3; i++) begin
        int e = pixv(base, y + j - 1, x + i - 1, c, w, h);
        int a = int'(win[(j*3+i)*DW +: DW]);
        check(a == e, (e == 0) ? "R4" : "R5", $sformatf("tap %0d of (%0d,%0d,%0d)", j*3+i, y, x, c), a, e);
      end
  endtask

  task automatic check_single(int base, int y, int x, int c, int w, int h, string req);
    int lat;
    int e = pixv(base, y, x, c, w, h);
    request(1, y, x, c, lat);
    check(lat == 2, "R8", "single latency", lat, 2);
    check(int'(px) == e, req, $sformatf("pixel (%0d,%0d,%0d)", y, x, c), int'(px), e);
  endtask

  initial begin
    int lat, extra;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
    check(rd_valid == 1'b0, "R1", "valid in reset", int'(rd_valid), 0);
    rst_n = 1;
    @(negedge clk);
    check(busy == 1'b0 && rd_valid == 1'b0, "R1", "idle after reset", int'({busy, rd_valid}), 0);

    // layer A: 5 wide, 6 high, 3 channels; ring of 4 lines = 60 words
    configure(5, 6, 3);
    push_rows(0, 0, 3, 5, 3);
    for (int y = 0; y <= 3; y++)
      for (int x = 0; x < 5; x++)
        for (int c = 0; c < 3; c++) check_single(0, y, x, c, 5, 6, "R2");
    check_single(0, -1, 2, 0, 5, 6, "R4");
    check_single(0, 2, 5, 1, 5, 6, "R4");
    for (int y = 0; y <= 2; y++)
      for (int x = 0; x < 5; x++)
        for (int c = 0; c < 3; c++) check_window(0, y, x, c, 5, 6);

    // R3 wrap: rows 4,5 replace lines 0,1; rows 2,3 survive
    push_rows(0, 4, 5, 5, 3);
    for (int y = 3; y <= 5; y++)
      for (int x = 0; x < 5; x++)
        for (int c = 0; c < 3; c++) check_window(0, y, x, c, 5, 6);
    check_single(0, 5, 4, 2, 5, 6, "R3");
    check_single(0, 2, 0, 0, 5, 6, "R3");

    // R6 excess words after 90 loads would land at ring position 30 = row 2 x0
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      wr_valid = 1; wr_data = 16'h7abc;
    end
    @(negedge clk);
    wr_valid = 0;
    check_single(0, 2, 0, 0, 5, 6, "R6");
    check_single(0, 2, 1, 1, 5, 6, "R6");

    // R9 request while busy is ignored
    @(negedge clk);
    req_valid = 1; req_single = 0; req_y = CW'(3); req_x = CW'(2); req_ch = CI_W'(1);
    @(negedge clk);
    req_valid = 0;
    lat = 0;
    repeat (2) begin @(negedge clk); lat++; end
    req_valid = 1; req_single = 1; req_y = CW'(5); req_x = CW'(0); req_ch = CI_W'(0);
    @(negedge clk);
    req_valid = 0; lat++;
    while (!rd_valid && lat < 40) begin @(negedge clk); lat++; end
    check(lat == 10, "R9", "latency with stray request", lat, 10);
    check(busy == 1'b0, "R9", "busy during pulse", int'(busy), 0);
    check(int'(win[4*DW +: DW]) == pixv(0, 3, 2, 1, 5, 6), "R9", "centre tap kept",
          int'(win[4*DW +: DW]), pixv(0, 3, 2, 1, 5, 6));
    extra = 0;
    repeat (12) begin @(negedge clk); if (rd_valid) extra++; end
    check(extra == 0, "R9", "extra pulses", extra, 0);

    // R7 new layer: 3 wide, 2 high, 2 channels; write position restarts at 0
    configure(3, 2, 2);
    push_rows(1000, 0, 1, 3, 2);
    check_single(1000, 0, 0, 0, 3, 2, "R7");
    check_single(1000, 1, 2, 1, 3, 2, "R7");
    for (int y = 0; y <= 1; y++)
      for (int x = 0; x < 3; x++)
        for (int c = 0; c < 2; c++) check_window(1000, y, x, c, 3, 2);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule